// File: doc/BRIEF.md
# Register window pointer and status controller

This block keeps the current window pointer and the invalid-window mask of a register-windowed integer unit with a 32-bit status word. It receives one-cycle command strobes: move to the next window down (save), move to the next window up (restore), return from trap, and write the status word. Every window move first looks up the mask bit of the window it would enter. If that bit is set, the move is refused and a trap request is raised instead. Return from trap is refused as well if traps are already enabled.

The block also owns the status fields that go with the window pointer: the four condition-code bits, the interrupt level, supervisor, previous-supervisor and enable-traps. It presents all of them as one packed status word. The number of windows is a parameter. The register storage, instruction decode and trap vectoring sit outside the block. They use the pointer output to pick a window and the trap pulse and code to start a trap.

Top module: `win_ptr_ctrl`

## Requirements
- R1: A save moves the pointer from w to w-1, and from 0 to NWIN-1, one cycle after the strobe, when the mask bit of the target window is clear.
- R2: A restore moves the pointer from w to w+1, and from NWIN-1 to 0, when the mask bit of the target window is clear.
- R3: A save whose target window has its mask bit set raises a trap with code 0x05 and leaves the pointer and all status fields unchanged.
- R4: A restore whose target window has its mask bit set raises a trap with code 0x06 and leaves the pointer and all status fields unchanged.
- R5: A return from trap issued while enable-traps is 1 raises a trap with code 0x02 and changes nothing. This check takes priority over the mask check.
- R6: A return from trap issued while enable-traps is 0 targets w+1 with wraparound. If that window's mask bit is set, it raises a trap with code 0x06 and changes nothing. Otherwise it moves the pointer, copies previous-supervisor into supervisor and sets enable-traps to 1.
- R7: A status write whose window field (data bits 4:0) is NWIN or more raises a trap with code 0x02 and changes nothing. Otherwise it loads the pointer from bits 4:0, the condition codes from 23:20, the interrupt level from 11:8, supervisor from bit 14, previous-supervisor from bit 13 and enable-traps from bit 12.
- R8: The status output is built combinationally from the current fields, using the bit positions of R7. All other bits read 0.
- R9: Each refused command produces exactly one cycle of trap request, in the cycle after the strobe, with its code. While no trap is requested, the code output is 0x00.
- R10: A mask write loads the mask from its own data input one cycle later. A window move in the same cycle is judged against the mask as it was before the write.
- R11: After reset the pointer is 0, the mask is 0, supervisor is 1, and all other fields and the trap request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_i | input | 1 | Save strobe (window down) |
| restore_i | input | 1 | Restore strobe (window up) |
| rett_i | input | 1 | Return-from-trap strobe |
| wrsr_i | input | 1 | Status-word write strobe |
| sr_data_i | input | 32 | Data for a status write |
| wim_we_i | input | 1 | Mask write enable |
| wim_data_i | input | NWIN | New invalid-window mask |
| cwp_o | output | CW | Current window pointer |
| wim_o | output | NWIN | Current invalid-window mask |
| sr_o | output | 32 | Packed status word |
| trap_o | output | 1 | Trap request pulse |
| trap_code_o | output | 8 | Trap type for the request |

## Verification
Two pairs of functions can meet in the same cycle. The first is a mask write together with a window move; the bench issues both on the same edge and expects the move to be judged against the old mask. The second is the two refusal rules of return from trap: the bench sets enable-traps and also sets the mask bit of the target window, and expects the illegal code to win. Random sequences repeat both overlaps, and a reference model in the bench predicts every pointer, mask, status word and trap code.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   localparam int SR_W    = 32;
   localparam int CWP_FW  = 5;
   localparam int ICC_LSB = 20;
   localparam int PIL_LSB = 8;
   localparam int S_BIT   = 14;
   localparam int PS_BIT  = 13;
   localparam int ET_BIT  = 12;

   typedef logic [7:0] tcode_t;
   localparam tcode_t TC_NONE = 8'h00;
   localparam tcode_t TC_ILL  = 8'h02;
   localparam tcode_t TC_OVF  = 8'h05;
   localparam tcode_t TC_UNF  = 8'h06;

   typedef enum logic [2:0] {
      OP_NONE, OP_SAVE, OP_REST, OP_RETT, OP_WRSR
   } op_t;

   typedef struct packed {
      logic [3:0] icc;
      logic [3:0] pil;
      logic       s;
      logic       ps;
      logic       et;
   } flags_t;
endpackage

// File: rtl/wpc_nextwin.sv
module wpc_nextwin #(
   parameter int NWIN = 8,
   parameter int CW   = 3
) (
   input  logic [CW-1:0] cwp_i,
   output logic [CW-1:0] up_o,
   output logic [CW-1:0] dn_o
);
   localparam logic [CW-1:0] LAST = CW'(NWIN - 1);
   localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         always_comb begin
            up_o = cwp_i + CW'(1);
            dn_o = cwp_i - CW'(1);
         end
      end else begin : g_cmp
         always_comb begin
            up_o = (cwp_i == LAST) ? '0 : cwp_i + CW'(1);
            dn_o = (cwp_i == '0) ? LAST : cwp_i - CW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/wpc_judge.sv
module wpc_judge
   import wpc_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int CW   = 3
) (
   input  op_t                op_i,
   input  logic [CW-1:0]      up_i,
   input  logic [CW-1:0]      dn_i,
   input  logic [NWIN-1:0]    wim_i,
   input  logic               et_i,
   input  logic [CWP_FW-1:0]  wr_field_i,
   output logic               commit_o,
   output logic [CW-1:0]      new_cwp_o,
   output logic               trap_o,
   output tcode_t             code_o
);
   logic field_bad;
   assign field_bad = ({27'd0, wr_field_i} >= 32'(NWIN));

   always_comb begin
      commit_o  = 1'b0;
      new_cwp_o = '0;
      trap_o    = 1'b0;
      code_o    = TC_NONE;
      unique case (op_i)
         OP_SAVE: begin
            if (wim_i[dn_i]) begin
               trap_o = 1'b1;
               code_o = TC_OVF;
            end else begin
               commit_o  = 1'b1;
               new_cwp_o = dn_i;
            end
         end
         OP_REST: begin
            if (wim_i[up_i]) begin
               trap_o = 1'b1;
               code_o = TC_UNF;
            end else begin
               commit_o  = 1'b1;
               new_cwp_o = up_i;
            end
         end
         OP_RETT: begin
            if (et_i) begin
               trap_o = 1'b1;
               code_o = TC_ILL;
            end else if (wim_i[up_i]) begin
               trap_o = 1'b1;
               code_o = TC_UNF;
            end else begin
               commit_o  = 1'b1;
               new_cwp_o = up_i;
            end
         end
         OP_WRSR: begin
            if (field_bad) begin
               trap_o = 1'b1;
               code_o = TC_ILL;
            end else begin
               commit_o  = 1'b1;
               new_cwp_o = wr_field_i[CW-1:0];
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      a_r9_no_commit_and_trap: assert (!(commit_o && trap_o));
   end
endmodule

// File: rtl/wpc_fields.sv
module wpc_fields
   import wpc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  op_t               op_i,
   input  logic              commit_i,
   input  logic [SR_W-1:0]   wr_data_i,
   output flags_t            flags_o
);
   flags_t q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '{icc: 4'h0, pil: 4'h0, s: 1'b1, ps: 1'b0, et: 1'b0};
      end else if (commit_i) begin
         if (op_i == OP_RETT) begin
            q.s  <= q.ps;
            q.et <= 1'b1;
         end else if (op_i == OP_WRSR) begin
            q.icc <= wr_data_i[ICC_LSB +: 4];
            q.pil <= wr_data_i[PIL_LSB +: 4];
            q.s   <= wr_data_i[S_BIT];
            q.ps  <= wr_data_i[PS_BIT];
            q.et  <= wr_data_i[ET_BIT];
         end
      end
   end

   assign flags_o = q;

   // R6: a successful return from trap leaves traps enabled
   a_r6_rett_sets_et: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_RETT && commit_i) |=> q.et);
   // R6: supervisor takes the old previous-supervisor
   a_r6_rett_copies_ps: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_RETT && commit_i) |=> (q.s == $past(q.ps)));
   // R3, R4: window moves leave the flags alone
   a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SAVE || op_i == OP_REST) |=> $stable(q));
endmodule

// File: rtl/win_ptr_ctrl.sv
module win_ptr_ctrl
   import wpc_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int CW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_i,
   input  logic              restore_i,
   input  logic              rett_i,
   input  logic              wrsr_i,
   input  logic [31:0]       sr_data_i,
   input  logic              wim_we_i,
   input  logic [NWIN-1:0]   wim_data_i,
   output logic [CW-1:0]     cwp_o,
   output logic [NWIN-1:0]   wim_o,
   output logic [31:0]       sr_o,
   output logic              trap_o,
   output logic [7:0]        trap_code_o
);
   generate
      if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
         $error("NWIN must be within 2..32");
      end
      if (CW != $clog2(NWIN)) begin : g_bad_cw
         $error("CW must equal clog2(NWIN)");
      end
   endgenerate

   localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

   op_t            op;
   logic [CW-1:0]  cwp_q, up_w, dn_w, new_cwp;
   logic [NWIN-1:0] wim_q;
   logic           commit, trap_w, trap_q;
   tcode_t         code_w, code_q;
   flags_t         flags;

   always_comb begin
      op = OP_NONE;
      if (save_i)         op = OP_SAVE;
      else if (restore_i) op = OP_REST;
      else if (rett_i)    op = OP_RETT;
      else if (wrsr_i)    op = OP_WRSR;
   end

   wpc_nextwin #(.NWIN(NWIN), .CW(CW)) u_next (
      .cwp_i (cwp_q),
      .up_o  (up_w),
      .dn_o  (dn_w)
   );

   wpc_judge #(.NWIN(NWIN), .CW(CW)) u_judge (
      .op_i       (op),
      .up_i       (up_w),
      .dn_i       (dn_w),
      .wim_i      (wim_q),
      .et_i       (flags.et),
      .wr_field_i (sr_data_i[CWP_FW-1:0]),
      .commit_o   (commit),
      .new_cwp_o  (new_cwp),
      .trap_o     (trap_w),
      .code_o     (code_w)
   );

   wpc_fields u_fields (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .commit_i  (commit),
      .wr_data_i (sr_data_i),
      .flags_o   (flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q  <= '0;
         wim_q  <= '0;
         trap_q <= 1'b0;
         code_q <= TC_NONE;
      end else begin
         if (commit)   cwp_q <= new_cwp;
         if (wim_we_i) wim_q <= wim_data_i;
         trap_q <= trap_w;
         code_q <= trap_w ? code_w : TC_NONE;
      end
   end

   always_comb begin
      sr_o = '0;
      sr_o[ICC_LSB +: 4]   = flags.icc;
      sr_o[PIL_LSB +: 4]   = flags.pil;
      sr_o[S_BIT]          = flags.s;
      sr_o[PS_BIT]         = flags.ps;
      sr_o[ET_BIT]         = flags.et;
      sr_o[CWP_FW-1:0]     = CWP_FW'(cwp_q);
   end

   assign cwp_o       = cwp_q;
   assign wim_o       = wim_q;
   assign trap_o      = trap_q;
   assign trap_code_o = code_q;

   // R9: strobes are mutually exclusive
   a_r9_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({save_i, restore_i, rett_i, wrsr_i}));
   // R1: save with clear target steps down with wrap
   a_r1_save_step: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && !wim_q[dn_w]) |=>
      (cwp_q == (($past(cwp_q) == '0) ? LAST : $past(cwp_q) - CW'(1))));
   // R2: restore with clear target steps up with wrap
   a_r2_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_i && !wim_q[up_w]) |=>
      (cwp_q == (($past(cwp_q) == LAST) ? '0 : $past(cwp_q) + CW'(1))));
   // R3: blocked save traps with overflow code
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && wim_q[dn_w]) |=> (trap_o && trap_code_o == TC_OVF && $stable(cwp_q)));
   // R4: blocked restore traps with underflow code
   a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_i && wim_q[up_w]) |=> (trap_o && trap_code_o == TC_UNF && $stable(cwp_q)));
   // R5: return from trap with traps enabled is illegal
   a_r5_rett_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (rett_i && flags.et) |=> (trap_o && trap_code_o == TC_ILL && $stable(cwp_q)));
   // R7: out-of-range window field is illegal
   a_r7_wrsr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wrsr_i && (sr_data_i[CWP_FW-1:0] >= CWP_FW'(NWIN))) |=>
      (trap_o && trap_code_o == TC_ILL && $stable(cwp_q) && $stable(flags)));
   // R9: code is zero without a request
   a_r9_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> (trap_code_o == TC_NONE));
   // R9: idle cycle gives no request next
   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !(save_i || restore_i || rett_i || wrsr_i) |=> !trap_o);
endmodule

// File: tb/sim_win_ptr_ctrl.sv
`timescale 1ns/1ps
module sim_win_ptr_ctrl;
   localparam int NWIN = 8;
   localparam int CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic save_i = 0, restore_i = 0, rett_i = 0, wrsr_i = 0, wim_we_i = 0;
   logic [31:0] sr_data_i = '0;
   logic [NWIN-1:0] wim_data_i = '0;
   logic [CW-1:0] cwp_o;
   logic [NWIN-1:0] wim_o;
   logic [31:0] sr_o;
   logic trap_o;
   logic [7:0] trap_code_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   win_ptr_ctrl #(.NWIN(NWIN)) u0 (
      .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
      .rett_i(rett_i), .wrsr_i(wrsr_i), .sr_data_i(sr_data_i),
      .wim_we_i(wim_we_i), .wim_data_i(wim_data_i), .cwp_o(cwp_o),
      .wim_o(wim_o), .sr_o(sr_o), .trap_o(trap_o), .trap_code_o(trap_code_o)
   );

   // reference state
   int m_cwp;
   logic [NWIN-1:0] m_wim;
   logic [3:0] m_icc, m_pil;
   logic m_s, m_ps, m_et, m_trap;
   logic [7:0] m_code;

   function automatic logic [31:0] pack_sr();
      logic [31:0] w = '0;
      w[23:20] = m_icc;
      w[11:8]  = m_pil;
      w[14] = m_s;
      w[13] = m_ps;
      w[12] = m_et;
      w[4:0] = 5'(m_cwp);
      return w;
   endfunction

   function automatic int wrap_up(int c);
      return (c == NWIN - 1) ? 0 : c + 1;
   endfunction

   function automatic int wrap_dn(int c);
      return (c == 0) ? NWIN - 1 : c - 1;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "cwp", 32'(cwp_o), 32'(m_cwp));
      chk("R8", "status", sr_o, pack_sr());
      chk("R10", "mask", 32'(wim_o), 32'(m_wim));
      chk("R9", "trap", 32'(trap_o), 32'(m_trap));
      chk("R9", "code", 32'(trap_code_o), 32'(m_code));
   endtask

   // op: 0 idle, 1 save, 2 restore, 3 rett, 4 status write
   task automatic step(int op, logic [31:0] d, logic we, logic [NWIN-1:0] wd, string tag);
      int tgt;
      save_i = (op == 1); restore_i = (op == 2); rett_i = (op == 3); wrsr_i = (op == 4);
      sr_data_i = d; wim_we_i = we; wim_data_i = wd;
      m_trap = 0; m_code = 8'h00;
      case (op)
         1: begin
            tgt = wrap_dn(m_cwp);
            if (m_wim[tgt]) begin m_trap = 1; m_code = 8'h05; end
            else m_cwp = tgt;
         end
         2: begin
            tgt = wrap_up(m_cwp);
            if (m_wim[tgt]) begin m_trap = 1; m_code = 8'h06; end
            else m_cwp = tgt;
         end
         3: begin
            tgt = wrap_up(m_cwp);
            if (m_et) begin m_trap = 1; m_code = 8'h02; end
            else if (m_wim[tgt]) begin m_trap = 1; m_code = 8'h06; end
            else begin m_cwp = tgt; m_s = m_ps; m_et = 1; end
         end
         4: begin
            if (int'(d[4:0]) >= NWIN) begin m_trap = 1; m_code = 8'h02; end
            else begin
               m_cwp = int'(d[4:0]); m_icc = d[23:20]; m_pil = d[11:8];
               m_s = d[14]; m_ps = d[13]; m_et = d[12];
            end
         end
         default: ;
      endcase
      if (we) m_wim = wd;
      @(posedge clk);
      @(negedge clk);
      save_i = 0; restore_i = 0; rett_i = 0; wrsr_i = 0; wim_we_i = 0;
      compare(tag);
   endtask

   function automatic logic [31:0] sr_word(int c, logic [3:0] icc, logic [3:0] pil,
                                           logic s, logic ps, logic et);
      logic [31:0] w = '0;
      w[4:0] = 5'(c); w[23:20] = icc; w[11:8] = pil;
      w[14] = s; w[13] = ps; w[12] = et;
      return w;
   endfunction

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      m_cwp = 0; m_wim = '0; m_icc = 0; m_pil = 0;
      m_s = 1; m_ps = 0; m_et = 0; m_trap = 0; m_code = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R11");

      step(1, 0, 0, 0, "R1");                 // 0 -> 7
      step(2, 0, 0, 0, "R2");                 // 7 -> 0
      step(1, 0, 1, 8'h80, "R10");            // judged on old mask: 0 -> 7
      step(2, 0, 0, 0, "R2");                 // 7 -> 0
      step(1, 0, 0, 0, "R3");                 // target 7 masked
      step(0, 0, 1, 8'h02, "R10");
      step(2, 0, 0, 0, "R4");                 // target 1 masked
      step(0, 0, 0, 0, "R9");                 // pulse ends
      step(4, sr_word(8, 4'hA, 4'h5, 1, 0, 1), 0, 0, "R7");
      step(4, 32'h0000_001F, 0, 0, "R7");
      step(4, sr_word(3, 4'hA, 4'h5, 1, 0, 1), 0, 0, "R7");
      step(3, 0, 0, 0, "R5");                 // traps enabled
      step(4, sr_word(1, 4'h3, 4'hC, 1, 0, 0), 0, 0, "R7");
      step(3, 0, 0, 0, "R6");                 // 1 -> 2, s <- 0, et <- 1
      step(4, sr_word(0, 4'h3, 4'hC, 0, 1, 0), 0, 0, "R7");
      step(3, 0, 0, 0, "R6");                 // target 1 masked
      step(4, sr_word(0, 4'h3, 4'hC, 0, 1, 1), 0, 0, "R7");
      step(3, 0, 0, 0, "R5");                 // both rules, illegal wins
      step(4, sr_word(7, 4'h1, 4'h2, 0, 1, 0), 1, 8'h00, "R7");
      step(2, 0, 0, 0, "R2");                 // 7 -> 0

      for (int i = 0; i < 3000; i++) begin
         int op;
         logic [31:0] d;
         logic we;
         logic [NWIN-1:0] wd;
         string tag;
         op = int'($urandom % 5);
         d = $urandom;
         if ($urandom % 4 != 0) d[4:0] = 5'($urandom % NWIN);
         we = ($urandom % 4 == 0);
         wd = NWIN'($urandom & $urandom & $urandom);
         case (op)
            1: tag = "R1";
            2: tag = "R2";
            3: tag = "R6";
            4: tag = "R7";
            default: tag = "R10";
         endcase
         step(op, d, we, wd, tag);
      end

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule